// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from eight peripheral modules and presents them to a processor through one interrupt line. A rising edge on a request input is captured as a pending request. Among the pending requests that are not masked, the lowest-numbered line wins. The interrupt line is raised only when that winner outranks every level that is already in service.

When the processor pulses its acknowledge input, the controller does three things. It moves the winning line from pending to in-service. In the next cycle it presents an 8-bit vector for that line together with a one-cycle valid strobe. The vector is a programmable 5-bit base followed by the 3-bit line number.

A request of strictly higher priority can nest over a level that is in service. A request of lower or equal priority waits until an end-of-service strobe retires the highest-priority in-service level. A mask register and the vector base register can both be written from the bus.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset `intr_out` and `vec_vld` are 0, the mask register is all zeros (every line enabled) and the vector base is 0.
- R2: A request is captured only on a 0-to-1 transition of its `irq_in` bit. A line held high after it has been serviced raises no new request.
- R3: `intr_out` is a registered output. It is 1 two clock edges after an eligible pending request that outranks all in-service levels appears, and 0 when no such request exists.
- R4: A captured request stays pending until it is acknowledged. An accepted acknowledge clears that line's pending bit and sets its in-service bit.
- R5: On the cycle after an accepted `inta` pulse, `vec_vld` is 1 for one cycle and `vec_out` = {base[4:0], line[2:0]}, with the line number in bits 2:0.
- R6: Priority is fixed: line 0 is the highest and line 7 the lowest.
- R7: A pending request raises `intr_out` over an in-service level only if its line number is strictly lower than that of the highest-priority in-service line. An equal or lower-priority request waits.
- R8: A pulse on `eos` clears only the highest-priority in-service bit. `intr_out` then reflects the new state on the following cycle.
- R9: While bit k of the mask register is 1, line k is never signalled or vectored, but its request stays pending. Clearing the bit makes it eligible again.
- R10: An `inta` pulse when no request qualifies produces no vector strobe and changes no state.
- R11: `intr_out` is 0 in the cycle after an accepted acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Request lines from the peripheral modules |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 8 | New mask value; 1 blocks the line |
| base_we | input | 1 | Write strobe for the vector base |
| base_wdata | input | 5 | New vector base |
| inta | input | 1 | Interrupt acknowledge pulse from the processor |
| eos | input | 1 | End-of-service pulse |
| intr_out | output | 1 | Interrupt line to the processor |
| vec_out | output | 8 | Vector of the acknowledged line |
| vec_vld | output | 1 | One-cycle strobe qualifying `vec_out` |

## Verification
The bench drives three kinds of ordering corner case:
- Nesting over an in-service level. A design that compares against the wrong in-service level, or uses less-than-or-equal, would interrupt on an equal or lower line, or fail to interrupt on a higher one.
- Simultaneous requests on several lines. A reversed priority encoder would return the vectors in the wrong order.
- A sequence of end-of-service pulses. A design that clears the wrong in-service bit would leave the wrong level blocking.

It also checks the remaining corner cases:
- A masked line must stay pending rather than be dropped, so it is vectored once it is unmasked.
- A held-high line must not re-trigger after it has been serviced.
- An acknowledge with nothing qualifying must produce no vector strobe.
- A change of the vector base must show up in the upper vector bits.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_LINES = 8;
  localparam int IRQ_VEC_W = 8;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set index wins; scan from top so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lines,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lines;
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    logic hit;
    assign hit = lines[g] & ~prev_q[g];
    always_ff @(posedge clk) begin
      if (rst)         pend[g] <= 1'b0;
      else if (hit)    pend[g] <= 1'b1;
      else if (clr[g]) pend[g] <= 1'b0;
    end
  end

  // a pending bit survives until its own clear
  assert_pend_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (pend & ~clr) != '0 |=> ((pend & $past(pend & ~clr)) == $past(pend & ~clr)));
endmodule

// File: rtl/irq_service_track.sv
module irq_service_track #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] isr
);
  always_ff @(posedge clk) begin
    if (rst) isr <= '0;
    else     isr <= (isr & ~clr) | set;
  end

  assert_one_set_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(set));

  assert_ack_sets_isr_R4: assert property (@(posedge clk) disable iff (rst)
    set != '0 |=> ((isr & $past(set)) == $past(set)));

  assert_eos_drops_one_R8: assert property (@(posedge clk) disable iff (rst)
    (clr != '0 && set == '0) |=> ($countones(isr) + 1 == $past($countones(isr))));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int N  = irq_pkg::IRQ_LINES,
  parameter int VW = irq_pkg::IRQ_VEC_W,
  localparam int IW = $clog2(N),
  localparam int BW = VW - IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_in,
  input  logic          mask_we,
  input  logic [N-1:0]  mask_wdata,
  input  logic          base_we,
  input  logic [BW-1:0] base_wdata,
  input  logic          inta,
  input  logic          eos,
  output logic          intr_out,
  output logic [VW-1:0] vec_out,
  output logic          vec_vld
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]  pend, isr, mask_q, elig, ack_set, eos_clr;
  logic [BW-1:0] base_q;
  logic          req_found, isr_busy, outrank, take;
  logic [IW-1:0] req_idx, isr_idx;

  assign elig = pend & ~mask_q;

  irq_prio_pick #(.N(N)) u_pick_req (.req(elig), .found(req_found), .idx(req_idx));
  irq_prio_pick #(.N(N)) u_pick_isr (.req(isr),  .found(isr_busy),  .idx(isr_idx));

  assign outrank = req_found && (!isr_busy || (req_idx < isr_idx));
  assign take    = inta && outrank;
  assign ack_set = take ? (ONE << req_idx) : '0;
  assign eos_clr = (eos && isr_busy) ? (ONE << isr_idx) : '0;

  irq_edge_latch #(.N(N)) u_latch (
    .clk(clk), .rst(rst), .lines(irq_in), .clr(ack_set), .pend(pend));

  irq_service_track #(.N(N)) u_svc (
    .clk(clk), .rst(rst), .set(ack_set), .clr(eos_clr), .isr(isr));

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      base_q   <= '0;
      intr_out <= 1'b0;
      vec_out  <= '0;
      vec_vld  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      if (base_we) base_q <= base_wdata;
      intr_out <= take ? 1'b0 : outrank;
      vec_vld  <= take;
      if (take) vec_out <= {base_q, req_idx};
    end
  end

  assert_vec_base_R5: assert property (@(posedge clk) disable iff (rst)
    vec_vld |-> (vec_out[VW-1:IW] == $past(base_q)));

  assert_mask_block_R9: assert property (@(posedge clk) disable iff (rst)
    vec_vld |-> !$past(mask_q[vec_out[IW-1:0]]));

  assert_intr_has_source_R3: assert property (@(posedge clk) disable iff (rst)
    intr_out |-> $past((pend & ~mask_q) != '0));
endmodule

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic       base_we = 1'b0;
  logic [4:0] base_wdata = '0;
  logic       inta = 1'b0;
  logic       eos = 1'b0;
  logic       intr_out;
  logic [7:0] vec_out;
  logic       vec_vld;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  vec_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .base_we(base_we), .base_wdata(base_wdata),
    .inta(inta), .eos(eos), .intr_out(intr_out), .vec_out(vec_out),
    .vec_vld(vec_vld));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every vector strobe
  always @(negedge clk) begin
    if (!rst && vec_vld) begin
      if (exp_q.size() == 0) begin
        chk("R10 unexpected vector", vec_out, 8'hxx);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk("R5 vector", vec_out, e);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(input logic [7:0] e);
    @(negedge clk);
    exp_q.push_back(e);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    chk("R11 intr low after ack", {7'd0, intr_out}, 8'd0);
  endtask

  task automatic spurious_ack();
    @(negedge clk);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    cyc(1);
  endtask

  task automatic end_svc();
    @(negedge clk);
    eos = 1'b1;
    @(negedge clk);
    eos = 1'b0;
  endtask

  task automatic put_req(input int line, input logic v);
    @(negedge clk);
    irq_in[line] = v;
  endtask

  task automatic write_mask(input logic [7:0] m);
    @(negedge clk);
    mask_we = 1'b1; mask_wdata = m;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic write_base(input logic [4:0] b);
    @(negedge clk);
    base_we = 1'b1; base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk("R1 reset intr", {7'd0, intr_out}, 8'd0);
    chk("R1 reset vld", {7'd0, vec_vld}, 8'd0);

    // R1: base reset to 0, mask clear -> line 3 gives vector 0x03
    put_req(3, 1'b1); cyc(3);
    chk("R3 intr raised", {7'd0, intr_out}, 8'd1);
    ack(8'h03); end_svc(); put_req(3, 1'b0); cyc(3);

    write_base(5'h13);  // vectors 0x98 + line

    // R2: level held after service does not re-request
    put_req(0, 1'b1); cyc(3);
    ack(8'h98); end_svc(); cyc(4);
    chk("R2 held level no retrigger", {7'd0, intr_out}, 8'd0);
    put_req(0, 1'b0); cyc(2);

    // R7 nesting
    put_req(5, 1'b1); cyc(3);
    ack(8'h9D); cyc(3);
    chk("R4 no intr with 5 in service", {7'd0, intr_out}, 8'd0);
    put_req(2, 1'b1); cyc(3);
    chk("R7 higher nests", {7'd0, intr_out}, 8'd1);
    ack(8'h9A);
    put_req(6, 1'b1); put_req(2, 1'b0); cyc(1); put_req(2, 1'b1); cyc(3);
    chk("R7 equal and lower wait", {7'd0, intr_out}, 8'd0);

    // R8 eos clears line 2 only; pending 2 outranks 5 again
    end_svc(); cyc(2);
    chk("R8 pending 2 over 5", {7'd0, intr_out}, 8'd1);
    ack(8'h9A); end_svc(); cyc(2);
    chk("R8 6 blocked by 5", {7'd0, intr_out}, 8'd0);
    end_svc(); cyc(2);
    chk("R8 6 after 5 retired", {7'd0, intr_out}, 8'd1);
    ack(8'h9E); end_svc(); cyc(2);
    chk("R8 all idle", {7'd0, intr_out}, 8'd0);
    irq_in = '0; cyc(2);

    // R6 fixed priority with three simultaneous requests
    @(negedge clk); irq_in = 8'b1000_1010; cyc(3);
    ack(8'h99); cyc(2);
    chk("R6 3 waits for 1", {7'd0, intr_out}, 8'd0);
    end_svc(); cyc(2);
    ack(8'h9B); end_svc(); cyc(2);
    ack(8'h9F); end_svc(); cyc(2);
    irq_in = '0; cyc(2);

    // R9 masking keeps the request pending
    write_mask(8'b0001_0000);
    put_req(4, 1'b1); cyc(4);
    chk("R9 masked line silent", {7'd0, intr_out}, 8'd0);
    put_req(6, 1'b1); cyc(3);
    chk("R9 other line passes", {7'd0, intr_out}, 8'd1);
    ack(8'h9E); end_svc(); cyc(2);
    write_base(5'h02);
    write_mask(8'h00); cyc(2);
    chk("R9 unmasked becomes eligible", {7'd0, intr_out}, 8'd1);
    ack(8'h14); end_svc(); cyc(2);
    irq_in = '0; cyc(2);

    // R10 acknowledge and eos with nothing qualifying
    spurious_ack(); end_svc(); cyc(2);
    chk("R10 no strobe", {7'd0, vec_vld}, 8'd0);
    chk("R10 intr stays low", {7'd0, intr_out}, 8'd0);

    chk("R5 scoreboard drained", 8'(exp_q.size()), 8'd0);
    summary();
  end
endmodule